// File: doc/BRIEF.md
# Amplifier Output Protection and Mode Controller

This block decides, every reference-clock cycle, whether the power output stage of a two-channel class-D amplifier may switch. It merges the power-down control, the output mute control and six fault sources into one output-stage enable. It also drives an open-drain alarm pin and a line-output enable. The six sources are a latched over-current trip, an over-temperature flag, a DC-on-input flag, low-voltage detection on a main rail and on a core rail, and a built-in monitor that flags a stopped or too-slow serial bit clock. All sense comparators sit outside the block and arrive as asynchronous digital levels. The bit clock arrives raw and is measured in the reference-clock domain.

Each fault has its own clearing rule. Over-current stays latched until power-down. Temperature and DC faults follow their inputs. Each rail fault is set by a low-threshold comparator and cleared by a separate high-threshold comparator, which gives hysteresis. The clock fault follows the most recent measurement window. The alarm pin is pulled low only for over-current and over-temperature. It is released (high impedance) during power-down and while either rail is low.

Top module: `amp_guard`

## Requirements
- R1: While `awake_i` is low (power-down), `stage_en_o`, `alarm_pull_o` and `line_en_o` are all 0. After reset, and before any input has propagated, the same three outputs are 0.
- R2: While `unmute_i` is low and `awake_i` is high, `stage_en_o` is 0 and `line_en_o` is 1.
- R3: `stage_en_o` is 1 only when `awake_i` and `unmute_i` are both high and no fault (over-current, temperature, DC, either rail, clock) is active. `alarm_pull_o` and `stage_en_o` are never 1 together.
- R4: A high level on `oc_trip_i` while awake sets an over-current fault. The fault stays set after `oc_trip_i` returns low, and it pulls the alarm pin low (`alarm_pull_o`=1).
- R5: `hot_i` high gives a temperature fault with `alarm_pull_o`=1. The fault clears as soon as `hot_i` falls again.
- R6: The clock monitor counts rising edges of `bclk_i` over windows of `WIN_CYC` reference cycles. At the end of each window, the clock fault is set if the count is below `min_edges_i` and cleared otherwise, so a count equal to the minimum passes. The fault is set from reset until the first window ends. It never pulls the alarm pin, and power-down does not clear it.
- R7: For each rail, a low-comparator input (`main_low_i`, `core_low_i`) sets that rail's fault and a high-comparator input (`main_ok_i`, `core_ok_i`) clears it. When neither is asserted the fault holds. When both are asserted, set wins. While either rail fault is set, `alarm_pull_o` is 0 even if an over-current or temperature fault is active.
- R8: `dc_trip_i` high gives a DC fault that disables the stage without pulling the alarm pin. The fault clears when `dc_trip_i` falls.
- R9: Every control and fault input passes through a two-stage synchronizer. A value sampled at a rising edge is reflected at the outputs right after the second rising edge that follows.
- R10: Power-down clears a latched over-current fault and both rail faults. After `awake_i` returns high, they stay clear unless their inputs set them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awake_i | input | 1 | High: operate; low: power-down |
| unmute_i | input | 1 | High: output stage allowed; low: muted |
| oc_trip_i | input | 1 | Over-current comparator, high = trip |
| hot_i | input | 1 | Over-temperature comparator, high = hot |
| dc_trip_i | input | 1 | DC-on-input detector, high = DC present |
| main_low_i | input | 1 | Main rail below falling threshold |
| main_ok_i | input | 1 | Main rail above rising threshold |
| core_low_i | input | 1 | Core rail below falling threshold |
| core_ok_i | input | 1 | Core rail above rising threshold |
| bclk_i | input | 1 | Raw serial bit clock to be monitored |
| min_edges_i | input | CNT_W | Minimum rising edges per window |
| stage_en_o | output | 1 | Output stage enable |
| alarm_pull_o | output | 1 | 1 = alarm pin driven low, 0 = released (high impedance) |
| line_en_o | output | 1 | Line-output enable |

## Verification
The assertions assume the inputs are sampled cleanly once they have crossed the synchronizers. They also assume that a reference to an input three cycles back is only meaningful three cycles after reset, so the checker counts cycles since reset before it applies those properties. The stimulus changes every input, including the bit clock, only at falling reference edges, so each value is stable at the rising edge that samples it. The bit clock is generated as a whole number of reference cycles per half period, and that includes a period that gives exactly the minimum edge count per window.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

    // bit positions inside the synchronized control vector
    localparam int IDX_AWAKE  = 0;
    localparam int IDX_UNMUTE = 1;
    localparam int IDX_OC     = 2;
    localparam int IDX_HOT    = 3;
    localparam int IDX_DC     = 4;
    localparam int IDX_MLOW   = 5;
    localparam int IDX_MOK    = 6;
    localparam int IDX_CLOW   = 7;
    localparam int IDX_COK    = 8;
    localparam int N_CTL      = 9;
    localparam int IDX_BCLK   = N_CTL;
    localparam int N_SYNC     = N_CTL + 1;

    localparam int NUM_RAILS  = 2;

    typedef struct packed {
        logic                 awake;
        logic                 unmuted;
        logic                 over_cur;
        logic                 over_temp;
        logic                 dc_hold;
        logic [NUM_RAILS-1:0] rail_low;
    } guard_state_t;

endpackage

// File: rtl/amp_guard_sync.sv
module amp_guard_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/amp_guard_clkmon.sv
module amp_guard_clkmon #(
    parameter int WIN_CYC = 64,
    parameter int CNT_W   = $clog2(WIN_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_s,
    input  logic [CNT_W-1:0] min_edges,
    output logic             stopped
);

    localparam int WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

    typedef struct packed {
        logic             prev;
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] edges;
        logic             stopped;
    } mon_t;

    mon_t mon_d, mon_q;
    logic             rise;
    logic [CNT_W-1:0] total;

    always_comb begin
        mon_d      = mon_q;
        rise       = bclk_s & ~mon_q.prev;
        total      = mon_q.edges + CNT_W'(rise);
        mon_d.prev = bclk_s;
        if (mon_q.win == WIN_LAST) begin
            mon_d.win     = '0;
            mon_d.edges   = '0;
            mon_d.stopped = (total < min_edges);
        end else begin
            mon_d.win   = mon_q.win + 1'b1;
            mon_d.edges = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q         <= '0;
            mon_q.stopped <= 1'b1;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign stopped = mon_q.stopped;

endmodule

// File: rtl/amp_guard_faults.sv
module amp_guard_faults
    import amp_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CTL-1:0] ctl_s,
    output guard_state_t     state
);

    guard_state_t st_d, st_q;
    logic [NUM_RAILS-1:0] rail_set, rail_clr;

    assign rail_set = {ctl_s[IDX_CLOW], ctl_s[IDX_MLOW]};
    assign rail_clr = {ctl_s[IDX_COK],  ctl_s[IDX_MOK]};

    always_comb begin
        st_d         = st_q;
        st_d.awake   = ctl_s[IDX_AWAKE];
        st_d.unmuted = ctl_s[IDX_UNMUTE];
        if (!ctl_s[IDX_AWAKE]) begin
            st_d.over_cur  = 1'b0;
            st_d.over_temp = 1'b0;
            st_d.dc_hold   = 1'b0;
            st_d.rail_low  = '0;
        end else begin
            st_d.over_cur  = st_q.over_cur | ctl_s[IDX_OC];
            st_d.over_temp = ctl_s[IDX_HOT];
            st_d.dc_hold   = ctl_s[IDX_DC];
            for (int r = 0; r < NUM_RAILS; r++) begin
                if (rail_set[r]) begin
                    st_d.rail_low[r] = 1'b1;
                end else if (rail_clr[r]) begin
                    st_d.rail_low[r] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/amp_guard.sv
module amp_guard
    import amp_guard_pkg::*;
#(
    parameter int WIN_CYC = 64,
    parameter int CNT_W   = $clog2(WIN_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             awake_i,
    input  logic             unmute_i,
    input  logic             oc_trip_i,
    input  logic             hot_i,
    input  logic             dc_trip_i,
    input  logic             main_low_i,
    input  logic             main_ok_i,
    input  logic             core_low_i,
    input  logic             core_ok_i,
    input  logic             bclk_i,
    input  logic [CNT_W-1:0] min_edges_i,
    output logic             stage_en_o,
    output logic             alarm_pull_o,
    output logic             line_en_o
);

    logic [N_SYNC-1:0] raw_vec, sync_vec;
    guard_state_t      st;
    logic              clk_stopped;
    logic              any_fault;
    logic              rail_any;

    always_comb begin
        raw_vec             = '0;
        raw_vec[IDX_AWAKE]  = awake_i;
        raw_vec[IDX_UNMUTE] = unmute_i;
        raw_vec[IDX_OC]     = oc_trip_i;
        raw_vec[IDX_HOT]    = hot_i;
        raw_vec[IDX_DC]     = dc_trip_i;
        raw_vec[IDX_MLOW]   = main_low_i;
        raw_vec[IDX_MOK]    = main_ok_i;
        raw_vec[IDX_CLOW]   = core_low_i;
        raw_vec[IDX_COK]    = core_ok_i;
        raw_vec[IDX_BCLK]   = bclk_i;
    end

    amp_guard_sync #(
        .W      (N_SYNC),
        .STAGES (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_vec),
        .sync_o  (sync_vec)
    );

    amp_guard_clkmon #(
        .WIN_CYC (WIN_CYC),
        .CNT_W   (CNT_W)
    ) u_clkmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_s    (sync_vec[IDX_BCLK]),
        .min_edges (min_edges_i),
        .stopped   (clk_stopped)
    );

    amp_guard_faults u_faults (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl_s (sync_vec[N_CTL-1:0]),
        .state (st)
    );

    always_comb begin
        rail_any     = |st.rail_low;
        any_fault    = st.over_cur | st.over_temp | st.dc_hold | rail_any | clk_stopped;
        stage_en_o   = st.awake & st.unmuted & ~any_fault;
        line_en_o    = st.awake;
        alarm_pull_o = st.awake & ~rail_any & (st.over_cur | st.over_temp);
    end

endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic awake_i,
    input logic unmute_i,
    input logic oc_trip_i,
    input logic stage_en_o,
    input logic alarm_pull_o,
    input logic line_en_o
);

    logic [1:0] age_q;
    logic       settled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign settled = (age_q == 2'd3);

    // R1: line output off forces stage and alarm off
    assert_sleep_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en_o |-> (!stage_en_o && !alarm_pull_o));

    // R3: alarm pulled and stage enabled never coexist
    assert_alarm_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pull_o |-> !stage_en_o);

    // R9: power-down reaches the line enable after the synchronizer delay
    assert_sleep_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(awake_i, 3) |-> !line_en_o);

    // R2: mute keeps line path alive while the stage is off
    assert_mute_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $past(awake_i, 3) && !$past(unmute_i, 3)) |-> (line_en_o && !stage_en_o));

    // R4: an over-current trip while awake disables the stage
    assert_oc_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $past(awake_i, 3) && $past(oc_trip_i, 3)) |-> !stage_en_o);

endmodule

bind amp_guard amp_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .awake_i      (awake_i),
    .unmute_i     (unmute_i),
    .oc_trip_i    (oc_trip_i),
    .stage_en_o   (stage_en_o),
    .alarm_pull_o (alarm_pull_o),
    .line_en_o    (line_en_o)
);

// File: tb/amp_guard_test.sv
`timescale 1ns/1ps
module amp_guard_test;

    localparam int WIN   = 64;
    localparam int CW    = $clog2(WIN + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic awake = 0, unmute = 0, oc = 0, hot = 0, dc = 0;
    logic mlow = 0, mok = 0, clow = 0, cok = 0, bclk = 0;
    logic [CW-1:0] min_edges = CW'(8);
    logic stage_en, alarm_pull, line_en;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string tag  = "R1";

    int half = 0;
    int hcnt = 0;

    // reference model state
    bit [9:0] hist[$];
    bit m_awake, m_unm, m_oc, m_ot, m_dc, m_cs;
    bit [1:0] m_rail;
    int m_win, m_edges;

    always #2.5 clk = ~clk;

    amp_guard #(.WIN_CYC(WIN)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .awake_i      (awake),
        .unmute_i     (unmute),
        .oc_trip_i    (oc),
        .hot_i        (hot),
        .dc_trip_i    (dc),
        .main_low_i   (mlow),
        .main_ok_i    (mok),
        .core_low_i   (clow),
        .core_ok_i    (cok),
        .bclk_i       (bclk),
        .min_edges_i  (min_edges),
        .stage_en_o   (stage_en),
        .alarm_pull_o (alarm_pull),
        .line_en_o    (line_en)
    );

    task automatic model_reset();
        hist.delete();
        repeat (3) hist.push_back(10'b0);
        m_awake = 0; m_unm = 0; m_oc = 0; m_ot = 0; m_dc = 0;
        m_rail = 0; m_cs = 1; m_win = 0; m_edges = 0;
    endtask

    task automatic model_step();
        bit [9:0] v, p;
        int tot;
        hist.push_back({bclk, cok, clow, mok, mlow, dc, hot, oc, unmute, awake});
        v = hist[hist.size()-3];
        p = hist[hist.size()-4];
        void'(hist.pop_front());
        // bit clock window measurement
        tot = m_edges + ((v[9] && !p[9]) ? 1 : 0);
        if (m_win == WIN - 1) begin
            m_cs = (tot < int'(min_edges));
            m_win = 0;
            m_edges = 0;
        end else begin
            m_win++;
            m_edges = tot;
        end
        // power-down, mute and faults
        m_awake = v[0];
        m_unm   = v[1];
        if (!v[0]) begin
            m_oc = 0; m_ot = 0; m_dc = 0; m_rail = 0;
        end else begin
            m_oc = m_oc | v[2];
            m_ot = v[3];
            m_dc = v[4];
            if (v[5]) m_rail[0] = 1; else if (v[6]) m_rail[0] = 0;
            if (v[7]) m_rail[1] = 1; else if (v[8]) m_rail[1] = 0;
        end
    endtask

    task automatic check_bit(input logic got, input bit exp, input string what);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic compare();
        bit fault;
        fault = m_oc | m_ot | m_dc | (|m_rail) | m_cs;
        check_bit(stage_en,   m_awake & m_unm & !fault, "stage_en");
        check_bit(line_en,    m_awake, "line_en");
        check_bit(alarm_pull, m_awake & !(|m_rail) & (m_oc | m_ot), "alarm_pull");
    endtask

    task automatic tick();
        if (half != 0) begin
            hcnt++;
            if (hcnt >= half) begin
                hcnt = 0;
                bclk = ~bclk;
            end
        end
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: reset state, all outputs low
        tag = "R1";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_bit(stage_en, 0, "reset stage_en");
            check_bit(line_en, 0, "reset line_en");
            check_bit(alarm_pull, 0, "reset alarm_pull");
        end
        rst_n = 1'b1;

        // R6: clock fault held from reset until the first good window
        tag = "R6"; half = 2; awake = 1; unmute = 1;
        run(40);
        run(120);

        // R2: mute
        tag = "R2"; unmute = 0; run(10); unmute = 1; run(10);

        // R1: power-down
        tag = "R1"; awake = 0; run(10); awake = 1; run(10);

        // R9: single-cycle pulses through the synchronizer
        tag = "R9"; unmute = 0; tick(); unmute = 1; run(5);
        awake = 0; tick(); awake = 1; run(5);

        // R4: over-current latches
        tag = "R4"; oc = 1; run(2); oc = 0; run(20);
        // R10: power-down clears it
        tag = "R10"; awake = 0; run(5); awake = 1; run(10);

        // R5: temperature follows input
        tag = "R5"; hot = 1; run(10); hot = 0; run(10);

        // R8: DC fault
        tag = "R8"; dc = 1; run(10); dc = 0; run(10);

        // R7: rail hysteresis, set priority, alarm override
        tag = "R7"; mlow = 1; run(5); mlow = 0; run(10);
        mok = 1; run(5); mok = 0; run(5);
        clow = 1; cok = 1; run(6); clow = 0; run(6); cok = 0; run(4);
        clow = 1; oc = 1; run(3); clow = 0; oc = 0; run(8);
        hot = 1; run(6);
        // R10: power-down clears rail fault and latched over-current
        tag = "R10"; awake = 0; hot = 0; run(5); awake = 1; run(10);

        // R3: combinations with mute
        tag = "R3"; unmute = 0; dc = 1; run(6); unmute = 1; run(6); dc = 0; run(8);

        // R6: slow, boundary, stopped, tighter minimum
        tag = "R6"; half = 10; run(200);
        half = 4; run(200);
        half = 0; run(200);
        awake = 0; run(10); awake = 1; run(10);
        half = 2; run(200);
        min_edges = CW'(20); run(200);
        min_edges = CW'(16); run(200);
        min_edges = CW'(8); run(150);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule